// File: doc/BRIEF.md
# Debug Exception Frame Sequencer

This block runs the memory traffic that saves and restores a processor exception frame while the core enters and leaves a debug mode. On an entry request it takes the status word, the resume program counter and the vector offset from the core. It lowers the stack pointer by the frame size and stores the frame with 32-bit writes. A return request makes it read the frame back field by field, hand the restored status word, program counter and format/vector word to the core, and raise the stack pointer by the size that the frame's format field names.

Frames come in two sizes. The basic frame is eight bytes (format 0): status word, program counter and format/vector word. The trace frame is twelve bytes (format 2) and adds the address of the last executed instruction. Every frame access is tagged for a separate debug address space, so the stack used by the sequence is kept apart from normal supervisor data. The memory port is a plain request/acknowledge port with a size bit. Choosing the vector, decoding instructions and the memory itself stay outside the block.

Top module: `dbg_frame_seq`

## Requirements
- R1: After reset the block is idle: busy, mem_req, sp_wr and rst_valid are all 0.
- R2: An entry request with entry_trace=0 makes exactly two 32-bit writes (mem_we=1, mem_long=1), to S-8 and S-4, where S is sp_in. The first carries {status word, PC[31:16]} and the second {PC[15:0], format/vector}. The format/vector word holds the format code in bits 15:12 (0 here) and the vector offset in bits 11:0. Memory is big-endian: the byte at an address is bits 31:24 of a 32-bit access.
- R3: An entry request with entry_trace=1 builds a twelve-byte frame at S-12. It makes three 32-bit writes to S-12, S-8 and S-4: the two words of R2 with format code 2, then entry_last_pc.
- R4: When a push completes, sp_out becomes sp_in minus the frame size (8 or 12), and sp_wr is 1 for the single cycle after the final acknowledge.
- R5: A return request reads, in this order, 16 bits at S (status word), 32 bits at S+2 (PC) and 16 bits at S+6 (format/vector), where S is sp_in. For 16-bit reads only mem_rdata[15:0] is used.
- R6: In the cycle after the final read acknowledge, rst_valid is 1 for exactly one cycle, with rst_sr, rst_pc and rst_fv holding the values read.
- R7: When a return completes, sp_out becomes S+12 if bits 15:12 of the format/vector word read equal 2, and S+8 for any other format, and sp_wr pulses for one cycle.
- R8: Every frame access has mem_alt=1 (the debug address space).
- R9: mem_req stays high with mem_addr, mem_we, mem_long and mem_wdata stable until mem_ack is seen. busy is 1 from the cycle after a request is accepted until the final acknowledge, and 0 when sp_wr pulses.
- R10: If entry_req and ret_req are both high in an idle cycle, the entry (push) is served. Requests that arrive while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Request to push a frame (sampled when idle) |
| entry_trace | input | 1 | 1 selects the twelve-byte trace frame |
| entry_sr | input | 16 | Status word to save |
| entry_pc | input | 32 | Resume PC to save |
| entry_last_pc | input | 32 | Last executed PC (trace frame only) |
| entry_vec_ofs | input | 12 | Vector offset for the format/vector word |
| ret_req | input | 1 | Request to restore a frame (sampled when idle) |
| sp_in | input | AW | Current stack pointer, sampled when a request is accepted |
| busy | output | 1 | A frame sequence is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_long | output | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| mem_alt | output | 1 | Debug address-space select |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data (16-bit reads in bits 15:0) |
| mem_ack | input | 1 | Access complete in this cycle |
| sp_out | output | AW | Updated stack pointer |
| sp_wr | output | 1 | One-cycle strobe: sp_out is new |
| rst_sr | output | 16 | Restored status word |
| rst_pc | output | 32 | Restored PC |
| rst_fv | output | 16 | Restored format/vector word |
| rst_valid | output | 1 | One-cycle strobe: restored values are valid |

## Verification
The assertions assume that mem_ack only comes while mem_req is high, and only as an answer to the access on the port at that moment, never early or for an old address. The bench memory model follows this: it acknowledges only in a cycle where it sees mem_req, after a programmable wait, and it services exactly the address and size on the port. Requests from the core are pulsed for one cycle at most. They are raised while busy only on purpose, to show that such requests are ignored.

// File: rtl/dbg_frame_pkg.sv
package dbg_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH0,
    ST_PUSH1,
    ST_PUSH2,
    ST_POP_SR,
    ST_POP_PC,
    ST_POP_FV
  } seq_st_t;

  localparam logic [3:0] FMT_BASIC = 4'h0;
  localparam logic [3:0] FMT_TRACE = 4'h2;

  // frame size in bytes selected by the format code
  function automatic logic [4:0] frame_bytes(input logic [3:0] fmt);
    return (fmt == FMT_TRACE) ? 5'd12 : 5'd8;
  endfunction

  // byte offset of each beat from the frame base
  function automatic logic [3:0] beat_offset(input seq_st_t s);
    case (s)
      ST_PUSH1:  return 4'd4;
      ST_PUSH2:  return 4'd8;
      ST_POP_PC: return 4'd2;
      ST_POP_FV: return 4'd6;
      default:   return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] make_fv(input logic [3:0] fmt, input logic [11:0] ofs);
    return {fmt, ofs};
  endfunction

endpackage

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dbg_frame_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_req,
  input  logic          entry_trace,
  input  logic          ret_req,
  input  logic [AW-1:0] sp_in,
  input  logic          mem_ack,
  input  logic [3:0]    rd_fmt,
  output seq_st_t       st,
  output logic          accept,
  output logic          beat_done,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_long,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] sp_out,
  output logic          sp_wr
);

  seq_st_t       st_q, st_d;
  logic [AW-1:0] base_q;
  logic          trace_q;
  logic          last_done;
  logic [3:0]    push_fmt;

  assign push_fmt  = entry_trace ? FMT_TRACE : FMT_BASIC;
  assign accept    = (st_q == ST_IDLE) && (entry_req || ret_req);
  assign mem_req   = (st_q != ST_IDLE);
  assign busy      = mem_req;
  assign beat_done = mem_req && mem_ack;
  assign mem_we    = (st_q == ST_PUSH0) || (st_q == ST_PUSH1) || (st_q == ST_PUSH2);
  assign mem_long  = !((st_q == ST_POP_SR) || (st_q == ST_POP_FV));
  assign mem_addr  = base_q + AW'(beat_offset(st_q));
  assign last_done = beat_done &&
                     (((st_q == ST_PUSH1) && !trace_q) || (st_q == ST_PUSH2) || (st_q == ST_POP_FV));
  assign st        = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (entry_req) st_d = ST_PUSH0;
                 else if (ret_req) st_d = ST_POP_SR;
      ST_PUSH0:  if (mem_ack) st_d = ST_PUSH1;
      ST_PUSH1:  if (mem_ack) st_d = trace_q ? ST_PUSH2 : ST_IDLE;
      ST_PUSH2:  if (mem_ack) st_d = ST_IDLE;
      ST_POP_SR: if (mem_ack) st_d = ST_POP_PC;
      ST_POP_PC: if (mem_ack) st_d = ST_POP_FV;
      ST_POP_FV: if (mem_ack) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      trace_q <= 1'b0;
      sp_out  <= '0;
      sp_wr   <= 1'b0;
    end else begin
      st_q  <= st_d;
      sp_wr <= last_done;
      if (accept) begin
        base_q  <= entry_req ? sp_in - AW'(frame_bytes(push_fmt)) : sp_in;
        trace_q <= entry_req && entry_trace;
      end
      if (last_done)
        sp_out <= (st_q == ST_POP_FV) ? base_q + AW'(frame_bytes(rd_fmt)) : base_q;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_long));

  // R4
  sp_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> !sp_wr);

  // R9
  idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |-> !busy);

endmodule

// File: rtl/dfs_pack.sv
module dfs_pack
  import dbg_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        trace,
  input  logic [15:0] sr,
  input  logic [31:0] pc,
  input  logic [31:0] last_pc,
  input  logic [11:0] vec_ofs,
  input  seq_st_t     st,
  output logic [31:0] wdata
);

  logic [15:0] sr_q, fv_q;
  logic [31:0] pc_q, lp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
      pc_q <= '0;
      lp_q <= '0;
      fv_q <= '0;
    end else if (load) begin
      sr_q <= sr;
      pc_q <= pc;
      lp_q <= last_pc;
      fv_q <= make_fv(trace ? FMT_TRACE : FMT_BASIC, vec_ofs);
    end
  end

  always_comb begin
    case (st)
      ST_PUSH0: wdata = {sr_q, pc_q[31:16]};
      ST_PUSH1: wdata = {pc_q[15:0], fv_q};
      ST_PUSH2: wdata = lp_q;
      default:  wdata = '0;
    endcase
  end

endmodule

// File: rtl/dfs_restore.sv
module dfs_restore
  import dbg_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  seq_st_t     st,
  input  logic        beat_done,
  input  logic [31:0] rdata,
  output logic [15:0] rst_sr,
  output logic [31:0] rst_pc,
  output logic [15:0] rst_fv,
  output logic        rst_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_sr    <= '0;
      rst_pc    <= '0;
      rst_fv    <= '0;
      rst_valid <= 1'b0;
    end else begin
      rst_valid <= beat_done && (st == ST_POP_FV);
      if (beat_done) begin
        case (st)
          ST_POP_SR: rst_sr <= rdata[15:0];
          ST_POP_PC: rst_pc <= rdata;
          ST_POP_FV: rst_fv <= rdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_valid |=> !rst_valid);

endmodule

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq
  import dbg_frame_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          entry_req,
  input  logic          entry_trace,
  input  logic [15:0]   entry_sr,
  input  logic [31:0]   entry_pc,
  input  logic [31:0]   entry_last_pc,
  input  logic [11:0]   entry_vec_ofs,
  input  logic          ret_req,
  input  logic [AW-1:0] sp_in,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_long,
  output logic          mem_alt,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic [AW-1:0] sp_out,
  output logic          sp_wr,
  output logic [15:0]   rst_sr,
  output logic [31:0]   rst_pc,
  output logic [15:0]   rst_fv,
  output logic          rst_valid
);

  seq_st_t st;
  logic    accept;
  logic    beat_done;
  logic    busy_w;

  dfs_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .entry_req(entry_req), .entry_trace(entry_trace), .ret_req(ret_req),
    .sp_in(sp_in), .mem_ack(mem_ack), .rd_fmt(mem_rdata[15:12]),
    .st(st), .accept(accept), .beat_done(beat_done), .busy(busy_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long), .mem_addr(mem_addr),
    .sp_out(sp_out), .sp_wr(sp_wr)
  );

  dfs_pack u_pack (
    .clk(clk), .rst_n(rst_n),
    .load(accept && entry_req), .trace(entry_trace),
    .sr(entry_sr), .pc(entry_pc), .last_pc(entry_last_pc), .vec_ofs(entry_vec_ofs),
    .st(st), .wdata(mem_wdata)
  );

  dfs_restore u_restore (
    .clk(clk), .rst_n(rst_n), .st(st), .beat_done(beat_done), .rdata(mem_rdata),
    .rst_sr(rst_sr), .rst_pc(rst_pc), .rst_fv(rst_fv), .rst_valid(rst_valid)
  );

  assign busy    = busy_w;
  assign mem_alt = busy_w;

  // R8
  alt_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_alt);

  // R9
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ack |=> $stable(mem_wdata));

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_valid |-> !mem_req);

endmodule

// File: tb/dbg_frame_seq_bench.sv
module dbg_frame_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0, entry_trace = 1'b0, ret_req = 1'b0;
  logic [15:0] entry_sr = '0;
  logic [31:0] entry_pc = '0, entry_last_pc = '0;
  logic [11:0] entry_vec_ofs = '0;
  logic [31:0] sp_in = '0;
  logic        busy, mem_req, mem_we, mem_long, mem_alt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack = 1'b0;
  logic [31:0] sp_out, rst_pc;
  logic [15:0] rst_sr, rst_fv;
  logic        sp_wr, rst_valid;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dbg_frame_seq u_dbg_frame_seq (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_trace(entry_trace),
    .entry_sr(entry_sr), .entry_pc(entry_pc), .entry_last_pc(entry_last_pc),
    .entry_vec_ofs(entry_vec_ofs), .ret_req(ret_req), .sp_in(sp_in), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long), .mem_alt(mem_alt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .sp_out(sp_out), .sp_wr(sp_wr), .rst_sr(rst_sr), .rst_pc(rst_pc), .rst_fv(rst_fv),
    .rst_valid(rst_valid)
  );

  // memory model: big-endian bytes, acknowledges after lat idle cycles
  logic [7:0]  mem [0:255];
  int          lat = 0, wcnt = 0, n_acc = 0, n_valid = 0;
  logic        log_we [0:15], log_long [0:15], log_alt [0:15];
  logic [31:0] log_addr [0:15];

  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {mem[a[7:0]], mem[a[7:0] + 8'd1]};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rd16(a), rd16(a + 32'd2)};
  endfunction

  always @(negedge clk) begin
    cycles++;
    mem_ack = 1'b0;
    if (rst_valid) n_valid++;
    if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_ack = 1'b1;
        if (n_acc < 16) begin
          log_we[n_acc] = mem_we; log_long[n_acc] = mem_long;
          log_alt[n_acc] = mem_alt; log_addr[n_acc] = mem_addr;
        end
        n_acc++;
        if (mem_we) begin
          for (int i = 0; i < 4; i++) mem[mem_addr[7:0] + 8'(i)] = mem_wdata[31-8*i -: 8];
        end else
          mem_rdata = mem_long ? rd32(mem_addr) : {16'hDEAD, rd16(mem_addr)};
      end else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr16(input logic [31:0] a, input logic [15:0] d);
    mem[a[7:0]] = d[15:8]; mem[a[7:0] + 8'd1] = d[7:0];
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      if (sp_wr) break;
      @(negedge clk);
    end
    chk(sp_wr, "R4", "sp_wr strobe seen", 32'(sp_wr), 32'd1);
    chk(!busy, "R9", "busy low at completion", 32'(busy), 32'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req, "R1", "idle after reset", {30'd0, busy, mem_req}, 32'd0);
    chk(!sp_wr && !rst_valid, "R1", "no strobes after reset", {30'd0, sp_wr, rst_valid}, 32'd0);
  endtask

  task automatic t_push(input bit trace, input logic [31:0] sp, input logic [15:0] sr,
                        input logic [31:0] pc, input logic [31:0] lp, input logic [11:0] vec,
                        input int l);
    logic [31:0] ns;
    int nb;
    string rq;
    nb = trace ? 3 : 2;
    ns = sp - (trace ? 32'd12 : 32'd8);
    rq = trace ? "R3" : "R2";
    lat = l; n_acc = 0;
    @(negedge clk);
    entry_req = 1'b1; entry_trace = trace; entry_sr = sr; entry_pc = pc;
    entry_last_pc = lp; entry_vec_ofs = vec; sp_in = sp;
    @(negedge clk);
    entry_req = 1'b0;
    chk(busy, "R9", "busy after accept", 32'(busy), 32'd1);
    wait_done();
    chk(n_acc == nb, rq, "write count", n_acc, nb);
    for (int i = 0; i < nb; i++) begin
      chk(log_we[i] && log_long[i], rq, "32-bit write", {30'd0, log_we[i], log_long[i]}, 32'd3);
      chk(log_addr[i] == ns + 32'(4 * i), rq, "write address", log_addr[i], ns + 32'(4 * i));
      chk(log_alt[i], "R8", "debug space tag", 32'(log_alt[i]), 32'd1);
    end
    chk(rd16(ns) == sr, rq, "status word", rd16(ns), sr);
    chk(rd32(ns + 2) == pc, rq, "PC field", rd32(ns + 2), pc);
    chk(rd16(ns + 6) == {trace ? 4'h2 : 4'h0, vec}, rq, "format/vector", rd16(ns + 6),
        {trace ? 4'h2 : 4'h0, vec});
    if (trace) chk(rd32(ns + 8) == lp, "R3", "last PC field", rd32(ns + 8), lp);
    chk(sp_out == ns, "R4", "stack pointer after push", sp_out, ns);
  endtask

  task automatic t_pop(input logic [31:0] sp, input logic [15:0] sr, input logic [31:0] pc,
                       input logic [15:0] fv, input int l);
    logic [31:0] exp_sp;
    exp_sp = sp + ((fv[15:12] == 4'h2) ? 32'd12 : 32'd8);
    wr16(sp, sr); wr16(sp + 2, pc[31:16]); wr16(sp + 4, pc[15:0]); wr16(sp + 6, fv);
    lat = l; n_acc = 0;
    @(negedge clk);
    ret_req = 1'b1; sp_in = sp;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done();
    chk(n_acc == 3, "R5", "read count", n_acc, 3);
    chk(!log_we[0] && !log_long[0] && log_addr[0] == sp, "R5", "first read 16-bit at S",
        log_addr[0], sp);
    chk(!log_we[1] && log_long[1] && log_addr[1] == sp + 2, "R5", "second read 32-bit at S+2",
        log_addr[1], sp + 2);
    chk(!log_we[2] && !log_long[2] && log_addr[2] == sp + 6, "R5", "third read 16-bit at S+6",
        log_addr[2], sp + 6);
    chk(log_alt[0] && log_alt[1] && log_alt[2], "R8", "reads tagged debug space",
        {29'd0, log_alt[0], log_alt[1], log_alt[2]}, 32'd7);
    chk(rst_valid, "R6", "valid with completion", 32'(rst_valid), 32'd1);
    chk(rst_sr == sr, "R6", "restored status word", rst_sr, sr);
    chk(rst_pc == pc, "R6", "restored PC", rst_pc, pc);
    chk(rst_fv == fv, "R6", "restored format/vector", rst_fv, fv);
    chk(sp_out == exp_sp, "R7", "stack pointer after return", sp_out, exp_sp);
    @(negedge clk);
    chk(!rst_valid, "R6", "valid lasts one cycle", 32'(rst_valid), 32'd0);
  endtask

  task automatic t_ignore_busy();
    int nv;
    lat = 2; n_acc = 0; nv = n_valid;
    @(negedge clk);
    entry_req = 1'b1; entry_trace = 1'b0; sp_in = 32'h0000_0060;
    @(negedge clk);
    entry_req = 1'b0;
    @(negedge clk);
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done();
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk(n_acc == 2, "R10", "request while busy ignored", n_acc, 2);
    chk(n_valid == nv, "R10", "no restore after ignored request", n_valid, nv);
  endtask

  task automatic t_both();
    lat = 0; n_acc = 0;
    @(negedge clk);
    entry_req = 1'b1; ret_req = 1'b1; entry_trace = 1'b0; sp_in = 32'h0000_00E0;
    @(negedge clk);
    entry_req = 1'b0; ret_req = 1'b0;
    wait_done();
    chk(n_acc == 2 && log_we[0], "R10", "entry wins over return", n_acc, 2);
    chk(sp_out == 32'h0000_00D8, "R10", "push stack pointer", sp_out, 32'h0000_00D8);
  endtask

  task automatic t_round_trip();
    t_push(1'b0, 32'h0000_00A0, 16'h2314, 32'h0BAD_F00D, 32'h0, 12'h030, 1);
    lat = 0; n_acc = 0;
    @(negedge clk);
    ret_req = 1'b1; sp_in = 32'h0000_0098;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done();
    chk(rst_pc == 32'h0BAD_F00D && rst_sr == 16'h2314, "R6", "round trip PC", rst_pc,
        32'h0BAD_F00D);
    chk(sp_out == 32'h0000_00A0, "R7", "round trip stack pointer", sp_out, 32'h0000_00A0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push(1'b0, 32'h0000_0080, 16'h2700, 32'h1234_5678, 32'h0, 12'h030, 0);
    t_push(1'b1, 32'h0000_00C0, 16'hA704, 32'hCAFE_0002, 32'hCAFE_FFFE, 12'h024, 3);
    t_pop(32'h0000_0040, 16'h2700, 32'h8765_4321, 16'h0030, 0);
    t_pop(32'h0000_0020, 16'h0011, 32'h0000_1110, 16'h2024, 2);
    t_pop(32'h0000_0010, 16'hFFFF, 32'hFFFF_FFFE, 16'h7030, 1);
    t_ignore_busy();
    t_both();
    t_round_trip();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule